// File: doc/BRIEF.md
# Standby Entry and Wake Controller

This block decides when a small microcontroller goes into its software standby low-power state and how it comes back out. A sleep strobe from the CPU, taken while the standby-select bit is set, stops the oscillator and gates the system clock. Several wake sources can end standby. An edge-selectable non-maskable interrupt pin wakes the chip unconditionally. Sixteen maskable interrupt lines, a group of key inputs and a group of wake-up inputs wake it only when the individual input is enabled and the CPU mask is clear.

An interrupt wake restarts the oscillator at once. The clock gate stays closed for a programmable settling interval, and the block then requests interrupt exception handling. A reset-pin wake is handled differently: the oscillator and the clock gate both turn on at once, and the reset exception is requested only when the pin is released. A low level on the hardware-standby pin overrides every other input in every state.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After reset the block is in the run state: `osc_en`=1, `clk_gate_en`=1, and `irq_exc_req`, `rst_exc_req` and `hw_stby` are 0.
- R2: In run, a clock edge that samples `sleep_stb`=1 with `stby_sel`=1 (both pins high) enters software standby, so that from the next cycle `osc_en`=0 and `clk_gate_en`=0.
- R3: An accepted wake seen in standby sets `osc_en`=1 from the next cycle. `clk_gate_en` then stays 0 for exactly 2^(SETTLE_BASE_LOG2+code) cycles, where `settle_sel` is sampled on the wake edge. After that `clk_gate_en` becomes 1 and `irq_exc_req` is high for one cycle.
- R4: Maskable line i wakes the block only when `irq_lines[i]`=1, `irq_en[i]`=1 and `cpu_mask`=0. Otherwise standby persists.
- R5: A key input or a wake-up input wakes the block only when it is high, its own enable bit is 1 and `cpu_mask`=0.
- R6: `nmi_edge_sel`=0 makes a falling edge of `nmi_pin` a wake and `nmi_edge_sel`=1 makes a rising edge a wake. An edge in the other direction does not wake. `cpu_mask` has no effect on this source.
- R7: `res_pin_n`=0 in standby or during settling sets `osc_en`=1 and `clk_gate_en`=1 from the next cycle, with no settling count. `rst_exc_req` pulses for one cycle in the cycle after the pin is sampled high, and no `irq_exc_req` follows.
- R8: `hwstby_pin_n`=0 moves the block to hardware standby from any state on the next cycle: `hw_stby`=1, `osc_en`=0 and `clk_gate_en`=0. This takes priority over sleep, wake and reset-pin inputs. When the pin is released, the reset-hold path of R7 follows.
- R9: In run, a sleep strobe with `stby_sel`=0 is ignored and the clock keeps running.
- R10: `settle_sel` codes 6 and 7 give the same settling length as code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, active in standby |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_stb | input | 1 | One-cycle sleep instruction strobe |
| stby_sel | input | 1 | Standby-select control bit |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| nmi_edge_sel | input | 1 | 0 selects the falling edge, 1 selects the rising edge |
| irq_lines | input | N_IRQ | Maskable interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| key_in | input | N_KEY | Key inputs |
| key_en | input | N_KEY | Per-key input enables |
| wue_in | input | N_WUE | Wake-up inputs |
| wue_en | input | N_WUE | Per-input wake-up enables |
| cpu_mask | input | 1 | CPU global interrupt mask |
| res_pin_n | input | 1 | Reset pin, active low |
| hwstby_pin_n | input | 1 | Hardware-standby pin, active low |
| settle_sel | input | 3 | Settling interval code |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | System clock gate enable |
| irq_exc_req | output | 1 | Interrupt exception request pulse |
| rst_exc_req | output | 1 | Reset exception request pulse |
| hw_stby | output | 1 | Hardware standby indication |

## Verification
Every output is decoded from the state register, and the exception pulses come from flops, so each response appears exactly one clock edge after the edge that samples the stimulus. The bench drives inputs on the falling edge and checks on the next falling edge. The settling length is measured by counting falling edges, starting at the first one after the wake, until `clk_gate_en` rises; for code c the count must equal 2^(base+c). The exception pulses are checked both on the cycle they are due and on the cycle after, so a pulse that is late, early or too wide is caught. The bench lowers the base exponent to 3, which keeps the longest interval at 256 cycles.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SWSTBY  = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_HWSTBY  = 3'd3,
    ST_RSTHOLD = 3'd4
  } stby_state_e;
endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
  parameter int N_IRQ = 16,
  parameter int N_KEY = 10,
  parameter int N_WUE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic             nmi_edge_sel,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_KEY-1:0] key_in,
  input  logic [N_KEY-1:0] key_en,
  input  logic [N_WUE-1:0] wue_in,
  input  logic [N_WUE-1:0] wue_en,
  input  logic             cpu_mask,
  output logic             nmi_hit,
  output logic             wake
);
  localparam int N_GRP = 3;

  logic nmi_q, nmi_vld;
  logic [N_GRP-1:0] grp_hit;

  // previous pin sample; edge detection is armed one cycle after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q   <= 1'b0;
      nmi_vld <= 1'b0;
    end else begin
      nmi_q   <= nmi_pin;
      nmi_vld <= 1'b1;
    end
  end

  always_comb begin
    if (nmi_edge_sel) nmi_hit = nmi_vld & nmi_pin & ~nmi_q;
    else              nmi_hit = nmi_vld & ~nmi_pin & nmi_q;
  end

  // per-group enable qualification
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    if (g == 0) begin : g_irq
      assign grp_hit[g] = |(irq_lines & irq_en);
    end else if (g == 1) begin : g_key
      assign grp_hit[g] = |(key_in & key_en);
    end else begin : g_wue
      assign grp_hit[g] = |(wue_in & wue_en);
    end
  end

  assign wake = nmi_hit | (~cpu_mask & (|grp_hit));

  AST_NMI_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_hit |-> (nmi_pin == nmi_edge_sel) && (nmi_q != nmi_pin)); // R6
endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
  parameter int BASE_LOG2 = 13,
  parameter int MAX_CODE  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [2:0] code,
  output logic       done
);
  localparam int         CW   = BASE_LOG2 + MAX_CODE + 1;
  localparam logic [2:0] MAXC = 3'(MAX_CODE);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic [2:0]    code_q, code_d, code_eff;
  logic          cnt_en;

  always_comb begin
    code_eff = (code_q > MAXC) ? MAXC : code_q;
    lim      = (CW'(1) << (BASE_LOG2 + int'(code_eff))) - CW'(1);
    done     = run && (cnt_q == lim);
    cnt_en   = start | run;
    cnt_d    = start ? '0 : cnt_q + CW'(1);
    code_d   = start ? code : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= lim); // R3
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_stb,
  input  logic        stby_sel,
  input  logic        wake,
  input  logic        res_pin_n,
  input  logic        hwstby_pin_n,
  input  logic        settle_done,
  output stby_state_e state,
  output logic        settle_start,
  output logic        settle_run,
  output logic        irq_exc_req,
  output logic        rst_exc_req
);
  stby_state_e st_q, st_d;
  logic irq_q, irq_d, rst_q, rst_d;

  always_comb begin
    st_d = st_q;
    if (!hwstby_pin_n) begin
      st_d = ST_HWSTBY;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (!res_pin_n)                st_d = ST_RSTHOLD;
          else if (sleep_stb && stby_sel) st_d = ST_SWSTBY;
        end
        ST_SWSTBY: begin
          if (!res_pin_n)  st_d = ST_RSTHOLD;
          else if (wake)   st_d = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (!res_pin_n)       st_d = ST_RSTHOLD;
          else if (settle_done) st_d = ST_RUN;
        end
        ST_RSTHOLD: begin
          if (res_pin_n) st_d = ST_RUN;
        end
        ST_HWSTBY: st_d = ST_RSTHOLD;
        default:   st_d = ST_RUN;
      endcase
    end
    settle_start = (st_q == ST_SWSTBY) && (st_d == ST_SETTLE);
    settle_run   = (st_q == ST_SETTLE);
    irq_d        = (st_q == ST_SETTLE)  && (st_d == ST_RUN);
    rst_d        = (st_q == ST_RSTHOLD) && (st_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  assign state       = st_q;
  assign irq_exc_req = irq_q;
  assign rst_exc_req = rst_q;

  AST_HW_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    !hwstby_pin_n |=> st_q == ST_HWSTBY); // R8
  AST_ENTER_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && sleep_stb && stby_sel && res_pin_n && hwstby_pin_n
      |=> st_q == ST_SWSTBY); // R2
  AST_SLEEP_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && !stby_sel && res_pin_n && hwstby_pin_n
      |=> st_q == ST_RUN); // R9
  AST_IRQ_EXC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(st_q) == ST_SETTLE && st_q == ST_RUN); // R3
  AST_RST_EXC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> $past(st_q) == ST_RSTHOLD && $past(res_pin_n)); // R7
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int N_IRQ            = 16,
  parameter int N_KEY            = 10,
  parameter int N_WUE            = 8,
  parameter int SETTLE_BASE_LOG2 = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_stb,
  input  logic             stby_sel,
  input  logic             nmi_pin,
  input  logic             nmi_edge_sel,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_KEY-1:0] key_in,
  input  logic [N_KEY-1:0] key_en,
  input  logic [N_WUE-1:0] wue_in,
  input  logic [N_WUE-1:0] wue_en,
  input  logic             cpu_mask,
  input  logic             res_pin_n,
  input  logic             hwstby_pin_n,
  input  logic [2:0]       settle_sel,
  output logic             osc_en,
  output logic             clk_gate_en,
  output logic             irq_exc_req,
  output logic             rst_exc_req,
  output logic             hw_stby
);
  logic [1:0]  rsync_q;
  logic        rst_i_n;
  logic        nmi_hit, wake, settle_start, settle_run, settle_done;
  stby_state_e state;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  stby_wake_qual #(.N_IRQ(N_IRQ), .N_KEY(N_KEY), .N_WUE(N_WUE)) u_qual (
    .clk(clk), .rst_n(rst_i_n), .nmi_pin(nmi_pin), .nmi_edge_sel(nmi_edge_sel),
    .irq_lines(irq_lines), .irq_en(irq_en), .key_in(key_in), .key_en(key_en),
    .wue_in(wue_in), .wue_en(wue_en), .cpu_mask(cpu_mask),
    .nmi_hit(nmi_hit), .wake(wake)
  );

  stby_settle_cnt #(.BASE_LOG2(SETTLE_BASE_LOG2), .MAX_CODE(5)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .start(settle_start), .run(settle_run),
    .code(settle_sel), .done(settle_done)
  );

  stby_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
    .wake(wake), .res_pin_n(res_pin_n), .hwstby_pin_n(hwstby_pin_n),
    .settle_done(settle_done), .state(state), .settle_start(settle_start),
    .settle_run(settle_run), .irq_exc_req(irq_exc_req), .rst_exc_req(rst_exc_req)
  );

  always_comb begin
    osc_en      = 1'b0;
    clk_gate_en = 1'b0;
    hw_stby     = 1'b0;
    unique case (state)
      ST_RUN:     begin osc_en = 1'b1; clk_gate_en = 1'b1; end
      ST_SETTLE:  osc_en = 1'b1;
      ST_RSTHOLD: begin osc_en = 1'b1; clk_gate_en = 1'b1; end
      ST_HWSTBY:  hw_stby = 1'b1;
      default:    ;
    endcase
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state == ST_SWSTBY) && cpu_mask && !nmi_hit && res_pin_n && hwstby_pin_n
      |=> !osc_en); // R4
  AST_RESPIN_CLK: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((state == ST_SWSTBY) || (state == ST_SETTLE)) && !res_pin_n && hwstby_pin_n
      |=> osc_en && clk_gate_en && !irq_exc_req); // R7
endmodule

// File: tb/sim_stby_wake_ctrl.sv
module sim_stby_wake_ctrl;
  localparam int BASE = 3;

  logic clk = 1'b0;
  logic rst_n, sleep_stb, stby_sel, nmi_pin, nmi_edge_sel, cpu_mask;
  logic res_pin_n, hwstby_pin_n;
  logic [15:0] irq_lines, irq_en;
  logic [9:0]  key_in, key_en;
  logic [7:0]  wue_in, wue_en;
  logic [2:0]  settle_sel;
  logic osc_en, clk_gate_en, irq_exc_req, rst_exc_req, hw_stby;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  stby_wake_ctrl #(.SETTLE_BASE_LOG2(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
    .nmi_pin(nmi_pin), .nmi_edge_sel(nmi_edge_sel), .irq_lines(irq_lines),
    .irq_en(irq_en), .key_in(key_in), .key_en(key_en), .wue_in(wue_in),
    .wue_en(wue_en), .cpu_mask(cpu_mask), .res_pin_n(res_pin_n),
    .hwstby_pin_n(hwstby_pin_n), .settle_sel(settle_sel), .osc_en(osc_en),
    .clk_gate_en(clk_gate_en), .irq_exc_req(irq_exc_req),
    .rst_exc_req(rst_exc_req), .hw_stby(hw_stby)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic go_standby(string req);
    @(negedge clk); sleep_stb = 1'b1; stby_sel = 1'b1;
    @(negedge clk); sleep_stb = 1'b0; stby_sel = 1'b0;
    chk({req, " standby osc"}, osc_en, 0);
    chk({req, " standby gate"}, clk_gate_en, 0);
  endtask

  // called at the first falling edge after the wake edge
  task automatic measure(string req, int exp);
    int n = 0;
    chk({req, " osc on"}, osc_en, 1);
    while (clk_gate_en === 1'b0 && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk({req, " settle len"}, n, exp);
    chk({req, " irq pulse"}, irq_exc_req, 1);
    @(negedge clk);
    chk({req, " irq pulse end"}, irq_exc_req, 0);
  endtask

  task automatic stays(string req);
    repeat (4) @(negedge clk);
    chk({req, " no wake"}, osc_en, 0);
  endtask

  task automatic t_reset();
    chk("R1 osc", osc_en, 1);
    chk("R1 gate", clk_gate_en, 1);
    chk("R1 pulses", {irq_exc_req, rst_exc_req, hw_stby}, 0);
  endtask

  task automatic t_sleep_ignored();
    @(negedge clk); sleep_stb = 1'b1; stby_sel = 1'b0;
    @(negedge clk); sleep_stb = 1'b0;
    chk("R9 gate", clk_gate_en, 1);
    repeat (3) @(negedge clk);
    chk("R9 osc", osc_en, 1);
  endtask

  task automatic t_irq();
    settle_sel = 3'd0;
    go_standby("R2");
    irq_en = 16'h0000; irq_lines = 16'h0020;
    stays("R4 disabled");
    irq_en = 16'h0020; cpu_mask = 1'b1;
    stays("R4 masked");
    @(negedge clk); cpu_mask = 1'b0;
    @(negedge clk); irq_lines = '0;
    measure("R4 R3 code0", 8);
    irq_en = '0;
  endtask

  task automatic t_key_wue();
    settle_sel = 3'd2;
    go_standby("R5");
    key_in = 10'h200; key_en = 10'h1FF;
    stays("R5 key disabled");
    key_en = 10'h200; cpu_mask = 1'b1;
    stays("R5 key masked");
    @(negedge clk); cpu_mask = 1'b0;
    @(negedge clk); key_in = '0;
    measure("R5 R3 code2", 32);
    key_en = '0;
    settle_sel = 3'd5;
    go_standby("R5");
    wue_in = 8'h01; wue_en = 8'h80;
    stays("R5 wue disabled");
    @(negedge clk); wue_en = 8'h01;
    @(negedge clk); wue_in = '0;
    measure("R5 R3 code5", 256);
    wue_en = '0;
  endtask

  task automatic t_codes_hi();
    for (int c = 6; c < 8; c++) begin
      settle_sel = 3'(c);
      go_standby("R10");
      @(negedge clk); irq_en = 16'h8000; irq_lines = 16'h8000;
      @(negedge clk); irq_lines = '0;
      measure("R10 clamp", 256);
      irq_en = '0;
    end
  endtask

  task automatic t_nmi();
    settle_sel = 3'd0;
    nmi_edge_sel = 1'b0;
    go_standby("R6");
    @(negedge clk); nmi_pin = 1'b1;
    stays("R6 wrong rising");
    @(negedge clk); nmi_pin = 1'b0;
    @(negedge clk);
    measure("R6 falling", 8);
    nmi_edge_sel = 1'b1; cpu_mask = 1'b1;
    go_standby("R6");
    @(negedge clk); nmi_pin = 1'b1;
    @(negedge clk);
    measure("R6 rising masked", 8);
    cpu_mask = 1'b0;
  endtask

  task automatic t_res_pin();
    go_standby("R7");
    @(negedge clk); res_pin_n = 1'b0;
    @(negedge clk);
    chk("R7 gate now", clk_gate_en, 1);
    chk("R7 osc now", osc_en, 1);
    repeat (3) @(negedge clk);
    chk("R7 no early rst", rst_exc_req, 0);
    res_pin_n = 1'b1;
    @(negedge clk);
    chk("R7 rst pulse", rst_exc_req, 1);
    @(negedge clk);
    chk("R7 rst pulse end", rst_exc_req, 0);
    settle_sel = 3'd5;
    go_standby("R7");
    @(negedge clk); irq_en = 16'h0001; irq_lines = 16'h0001;
    @(negedge clk); irq_lines = '0;
    repeat (5) @(negedge clk);
    res_pin_n = 1'b0;
    @(negedge clk);
    chk("R7 settle abort gate", clk_gate_en, 1);
    res_pin_n = 1'b1;
    @(negedge clk);
    chk("R7 rst after settle", rst_exc_req, 1);
    repeat (300) @(negedge clk);
    chk("R7 no irq later", irq_exc_req, 0);
    irq_en = '0;
  endtask

  task automatic t_hw();
    @(negedge clk); hwstby_pin_n = 1'b0; sleep_stb = 1'b1; stby_sel = 1'b1;
    @(negedge clk); sleep_stb = 1'b0; stby_sel = 1'b0; res_pin_n = 1'b0;
    chk("R8 hw flag", hw_stby, 1);
    chk("R8 clocks off", {osc_en, clk_gate_en}, 0);
    repeat (3) @(negedge clk);
    chk("R8 over res pin", hw_stby, 1);
    res_pin_n = 1'b1; hwstby_pin_n = 1'b1;
    @(negedge clk);
    chk("R8 release hold", {hw_stby, clk_gate_en, rst_exc_req}, 3'b010);
    @(negedge clk);
    chk("R8 release rst", rst_exc_req, 1);
    settle_sel = 3'd0;
    go_standby("R8");
    @(negedge clk); hwstby_pin_n = 1'b0; wue_en = 8'h02; wue_in = 8'h02;
    @(negedge clk); wue_in = '0;
    chk("R8 over wake", {hw_stby, osc_en}, 2'b10);
    hwstby_pin_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 back run", clk_gate_en, 1);
    wue_en = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sleep_stb = 1'b0; stby_sel = 1'b0; nmi_pin = 1'b0;
    nmi_edge_sel = 1'b0; cpu_mask = 1'b0; res_pin_n = 1'b1; hwstby_pin_n = 1'b1;
    irq_lines = '0; irq_en = '0; key_in = '0; key_en = '0;
    wue_in = '0; wue_en = '0; settle_sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sleep_ignored();
    t_irq();
    t_key_wue();
    t_codes_hi();
    t_nmi();
    t_res_pin();
    t_hw();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule